// File: doc/BRIEF.md
# RTC Supply Supervisor and Snapshot Controller

This block keeps the supply-related status of a battery-backed real-time clock. It tracks whether timekeeping has been lost since power-up (a timekeeping-lost flag that only a clock start removes), reports low battery while the clock runs from its backup cell, raises a sticky power-fail interrupt flag, and holds a snapshot-follow enable. While that enable is set, the snapshot memory copies the live time registers on every cycle. The enable drops by itself at the moment the supply changes over to the battery, so the last copy taken is the time at changeover.

The block also produces a bus lock-out. The lock-out is active whenever the power-fail input or the battery supply is active. It is released only after a debounce interval, counted in `tick` pulses, has passed with the main supply good. The analog comparators, the oscillator and the time counters are outside the block and appear only as digital inputs.

Top module: `rtc_supply_supervisor`

## Requirements
- R1: After reset, osc_fail=1, clk_run=0, pf_irq_en=0, tsave_en=0, batt_mode=0, pf_flag=0, low_batt=0 and bus_lock=1.
- R2: A write to the control register (address 0) with bit 0 (clock run) set clears osc_fail on the next cycle. Nothing except reset sets osc_fail again.
- R3: Writes to control bit 3 (battery-backed mode select), with either value, update batt_mode on the next cycle and leave osc_fail unchanged.
- R4: Each cycle, low_batt takes the value pf_irq_en AND on_battery AND lowbat_cmp sampled at the previous clock edge.
- R5: While pf_irq_en (control bit 1) is 0, low_batt stays 0 and pf_flag is never set.
- R6: A rising edge of pfail_in while pf_irq_en=1 sets pf_flag on the next cycle. Writing 1 to bit 0 of the status register (address 1) clears the flag; a set in the same cycle wins. irq_out equals pf_flag AND pf_irq_en.
- R7: tsave_copy is 1 in every cycle in which tsave_en is 1, and 0 otherwise.
- R8: A rising edge of on_battery clears tsave_en on the next cycle, and this takes priority over a write in the same cycle. A power-fail rising edge alone leaves tsave_en unchanged.
- R9: bus_lock is 1 in any cycle where pfail_in or on_battery is 1, whatever the value of pf_irq_en.
- R10: Once both pfail_in and on_battery are 0, the first such cycle only arms the counter. bus_lock drops on the cycle after the DEBOUNCE_TICKS-th tick seen after that. After reset, counting begins at once. Any return of a power-bad input restarts the count.
- R11: A control-register write sets or clears tsave_en from bit 2 on the next cycle when there is no battery changeover. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| on_battery | input | 1 | 1 while running from the backup cell |
| pfail_in | input | 1 | Power-fail indication, active high |
| lowbat_cmp | input | 1 | Comparator result, 1 when the cell is below threshold |
| tick | input | 1 | Debounce time-base pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| clk_run | output | 1 | Clock run bit |
| pf_irq_en | output | 1 | Power-fail interrupt enable |
| tsave_en | output | 1 | Snapshot-follow enable |
| batt_mode | output | 1 | Battery-backed mode select |
| osc_fail | output | 1 | Timekeeping-lost flag |
| low_batt | output | 1 | Low-battery status |
| pf_flag | output | 1 | Sticky power-fail interrupt flag |
| irq_out | output | 1 | Power-fail interrupt request |
| tsave_copy | output | 1 | Snapshot copy strobe |
| bus_lock | output | 1 | Bus lock-out |

## Verification
All register and status results, including osc_fail, low_batt, pf_flag, tsave_en and the release of bus_lock, are due one clock edge after the inputs that cause them. The assertion of bus_lock, irq_out and tsave_copy follows the current cycle's state with no delay. The bench drives inputs on the falling edge and advances a reference model over the same rising edge. It compares every output at the next falling edge, before it drives new inputs, so same-cycle and next-cycle results are checked at their due point.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_PFEN  = 1;
  localparam int unsigned B_TSAVE = 2;
  localparam int unsigned B_BMODE = 3;
  localparam int unsigned B_PFCLR = 0;

  typedef enum logic [1:0] {
    LK_HOLD   = 2'd0,
    LK_SETTLE = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  function automatic logic lowbat_detect(input logic enable, input logic battery,
                                         input logic below);
    return enable & battery & below;
  endfunction

  function automatic logic rise_of(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  function automatic logic last_tick(input int unsigned count, input int unsigned limit);
    return (count + 1) >= limit;
  endfunction
endpackage

// File: rtl/rss_ctrl_regs.sv
module rss_ctrl_regs
  import rss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bat_rise,
  output logic              clk_run,
  output logic              pf_irq_en,
  output logic              tsave_en,
  output logic              batt_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_run   <= 1'b0;
      pf_irq_en <= 1'b0;
      batt_mode <= 1'b0;
    end else if (ctrl_wr) begin
      clk_run   <= wr_data[B_RUN];
      pf_irq_en <= wr_data[B_PFEN];
      batt_mode <= wr_data[B_BMODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tsave_en <= 1'b0;
    else if (bat_rise) tsave_en <= 1'b0;
    else if (ctrl_wr)  tsave_en <= wr_data[B_TSAVE];
  end

  p_tsave_autoclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bat_rise |=> !tsave_en);
  p_tsave_sw_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bat_rise) |=> (tsave_en == $past(wr_data[B_TSAVE])));
  p_tsave_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !bat_rise) |=> $stable(tsave_en));
endmodule

// File: rtl/rss_status.sv
module rss_status
  import rss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic pf_irq_en,
  input  logic on_battery,
  input  logic lowbat_cmp,
  input  logic pf_rise,
  input  logic flag_clr,
  output logic osc_fail,
  output logic low_batt,
  output logic pf_flag
);
  logic flag_set;
  assign flag_set = pf_rise & pf_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         osc_fail <= 1'b1;
    else if (start_evt) osc_fail <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_batt <= 1'b0;
    else        low_batt <= lowbat_detect(pf_irq_en, on_battery, lowbat_cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pf_flag <= 1'b0;
    else if (flag_set) pf_flag <= 1'b1;
    else if (flag_clr) pf_flag <= 1'b0;
  end

  p_osc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !osc_fail);
  p_osc_no_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_fail |=> !osc_fail);
  p_lowbat_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_irq_en |=> !low_batt);
  p_flag_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_irq_en && !pf_flag) |=> !pf_flag);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_rise && pf_irq_en) |=> pf_flag);
endmodule

// File: rtl/rss_lockout.sv
module rss_lockout
  import rss_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_bad,
  input  logic tick,
  output logic bus_lock
);
  localparam int unsigned CW = $clog2(DEBOUNCE_TICKS + 1);

  lock_state_e      state;
  logic [CW-1:0]    cnt;
  logic             settle_done;

  assign settle_done = tick && last_tick(int'(cnt), DEBOUNCE_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LK_SETTLE;
      cnt   <= '0;
    end else if (power_bad) begin
      state <= LK_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        LK_HOLD: begin
          state <= LK_SETTLE;
          cnt   <= '0;
        end
        LK_SETTLE: begin
          if (settle_done) begin
            state <= LK_OPEN;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= LK_OPEN;
      endcase
    end
  end

  assign bus_lock = power_bad | (state != LK_OPEN);

  p_release_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(tick));
  p_count_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < DEBOUNCE_TICKS);
  p_open_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_lock && !power_bad) |=> (state == LK_OPEN));
endmodule

// File: rtl/rtc_supply_supervisor.sv
module rtc_supply_supervisor
  import rss_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_battery,
  input  logic       pfail_in,
  input  logic       lowbat_cmp,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       clk_run,
  output logic       pf_irq_en,
  output logic       tsave_en,
  output logic       batt_mode,
  output logic       osc_fail,
  output logic       low_batt,
  output logic       pf_flag,
  output logic       irq_out,
  output logic       tsave_copy,
  output logic       bus_lock
);
  logic pfail_q, batt_q;
  logic ctrl_wr, stat_wr, start_evt, flag_clr, bat_rise, pf_rise, power_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfail_q <= 1'b0;
      batt_q  <= 1'b0;
    end else begin
      pfail_q <= pfail_in;
      batt_q  <= on_battery;
    end
  end

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign stat_wr   = wr_en && (wr_addr == A_STAT);
  assign start_evt = ctrl_wr && wr_data[B_RUN];
  assign flag_clr  = stat_wr && wr_data[B_PFCLR];
  assign bat_rise  = rise_of(on_battery, batt_q);
  assign pf_rise   = rise_of(pfail_in, pfail_q);
  assign power_bad = pfail_in | on_battery;

  rss_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
    .bat_rise(bat_rise), .clk_run(clk_run), .pf_irq_en(pf_irq_en),
    .tsave_en(tsave_en), .batt_mode(batt_mode)
  );

  rss_status u_status (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .pf_irq_en(pf_irq_en),
    .on_battery(on_battery), .lowbat_cmp(lowbat_cmp), .pf_rise(pf_rise),
    .flag_clr(flag_clr), .osc_fail(osc_fail), .low_batt(low_batt), .pf_flag(pf_flag)
  );

  rss_lockout #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .power_bad(power_bad), .tick(tick), .bus_lock(bus_lock)
  );

  assign irq_out    = pf_flag & pf_irq_en;
  assign tsave_copy = tsave_en;

  p_lock_on_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail_in || on_battery) |-> bus_lock);
  p_bmode_keeps_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[B_RUN]) |=> (osc_fail == $past(osc_fail)));
  p_pfail_keeps_tsave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_rise && !on_battery && !wr_en) |=> (tsave_en == $past(tsave_en)));
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_irq_en |-> !irq_out);
endmodule

// File: tb/rtc_supply_supervisor_tb.sv
module rtc_supply_supervisor_tb_top;
  localparam int unsigned DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_battery = 1'b0, pfail_in = 1'b0, lowbat_cmp = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic clk_run, pf_irq_en, tsave_en, batt_mode, osc_fail, low_batt, pf_flag;
  logic irq_out, tsave_copy, bus_lock;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic m_run, m_en, m_ts, m_bm, m_osc, m_lb, m_flag, m_pfq, m_batq;
  int   m_phase, m_seen;

  always #5 clk = ~clk;

  rtc_supply_supervisor #(.DEBOUNCE_TICKS(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .on_battery(on_battery), .pfail_in(pfail_in),
    .lowbat_cmp(lowbat_cmp), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clk_run(clk_run), .pf_irq_en(pf_irq_en),
    .tsave_en(tsave_en), .batt_mode(batt_mode), .osc_fail(osc_fail),
    .low_batt(low_batt), .pf_flag(pf_flag), .irq_out(irq_out),
    .tsave_copy(tsave_copy), .bus_lock(bus_lock)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_lock();
    return pfail_in || on_battery || (m_phase != 2);
  endfunction

  task automatic model_reset();
    m_run = 0; m_en = 0; m_ts = 0; m_bm = 0; m_osc = 1; m_lb = 0; m_flag = 0;
    m_pfq = 0; m_batq = 0; m_phase = 1; m_seen = 0;
  endtask

  // advance the model by one clock edge using current inputs
  task automatic model_edge();
    logic cw, sw, br, pr;
    cw = wr_en && wr_addr == 2'd0;
    sw = wr_en && wr_addr == 2'd1;
    br = on_battery && !m_batq;
    pr = pfail_in && !m_pfq;
    m_lb = m_en && on_battery && lowbat_cmp;
    if (pr && m_en) m_flag = 1;
    else if (sw && wr_data[0]) m_flag = 0;
    if (cw && wr_data[0]) m_osc = 0;
    if (br) m_ts = 0;
    else if (cw) m_ts = wr_data[2];
    if (cw) begin m_run = wr_data[0]; m_en = wr_data[1]; m_bm = wr_data[3]; end
    if (pfail_in || on_battery) begin m_phase = 0; m_seen = 0; end
    else if (m_phase == 0) begin m_phase = 1; m_seen = 0; end
    else if (m_phase == 1 && tick) begin
      m_seen++;
      if (m_seen >= DEB) begin m_phase = 2; m_seen = 0; end
    end
    m_pfq = pfail_in;
    m_batq = on_battery;
  endtask

  task automatic compare_all();
    chk("R2 osc_fail", osc_fail, m_osc);
    chk("R3 batt_mode", batt_mode, m_bm);
    chk("R11 clk_run", clk_run, m_run);
    chk("R11 pf_irq_en", pf_irq_en, m_en);
    chk("R8 tsave_en", tsave_en, m_ts);
    chk("R4 low_batt", low_batt, m_lb);
    chk("R6 pf_flag", pf_flag, m_flag);
    chk("R6 irq_out", irq_out, m_flag & m_en);
    chk("R7 tsave_copy", tsave_copy, m_ts);
    chk("R9 bus_lock", bus_lock, exp_lock());
  endtask

  // inputs are set before the call; one edge, then compare at negedge
  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0; tick = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 osc_fail", osc_fail, 1'b1);
    chk("R1 clk_run", clk_run, 1'b0);
    chk("R1 tsave_en", tsave_en, 1'b0);
    chk("R1 pf_flag", pf_flag, 1'b0);
    chk("R1 bus_lock", bus_lock, 1'b1);
    chk("R1 pf_irq_en", pf_irq_en, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R3: toggle battery mode bit, osc_fail must hold
    wr(2'd0, 8'h08); chk("R3 osc kept after bmode=1", osc_fail, 1'b1);
    wr(2'd0, 8'h00); chk("R3 osc kept after bmode=0", osc_fail, 1'b1);
    // R11: writes to unused addresses change nothing
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    chk("R11 unused addr no run", clk_run, 1'b0);
    // R10: exactly DEB ticks after reset release the bus
    for (int i = 0; i < DEB; i++) begin
      chk("R10 still locked", bus_lock, 1'b1);
      tick = 1; step();
    end
    chk("R10 released", bus_lock, 1'b0);
    // R2: start the clock
    wr(2'd0, 8'h07); chk("R2 osc cleared on start", osc_fail, 1'b0);
    // R8: pfail alone keeps tsave; R9 locks even though masked later
    pfail_in = 1; step(); chk("R8 pfail keeps tsave", tsave_en, 1'b1);
    chk("R6 flag set", pf_flag, 1'b1);
    pfail_in = 0; step();
    wr(2'd1, 8'h01); chk("R6 flag cleared", pf_flag, 1'b0);
    wr(2'd0, 8'h05); // mask interrupt, keep run and tsave
    pfail_in = 1; step(); chk("R9 lock while masked", bus_lock, 1'b1);
    chk("R5 no flag when masked", pf_flag, 1'b0);
    pfail_in = 0; step();
    on_battery = 1; lowbat_cmp = 1; step();
    chk("R8 tsave cleared on changeover", tsave_en, 1'b0);
    step(); chk("R5 no low_batt when masked", low_batt, 1'b0);
    on_battery = 0; lowbat_cmp = 0; step();

    // constrained random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(59) == 0) on_battery = ~on_battery;
      pfail_in = ($urandom_range(29) == 0);
      lowbat_cmp = $urandom_range(1);
      tick = ($urandom_range(3) == 0);
      if ($urandom_range(5) == 0) begin
        wr_en = 1;
        wr_addr = 2'($urandom_range(3));
        wr_data = 8'($urandom);
      end
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule